// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block gathers level-sensitive interrupt requests from a parameterised set of sources and delivers them to several targets (contexts). Each context has one interrupt output line. Every source carries a small priority. Each context owns an enable vector and a priority threshold. A context's line is raised while at least one source is eligible for it. A source is eligible when it is requested, enabled for that context, not already being serviced, and has a priority strictly above the threshold.

Software drives the block through a 32-bit word register port. A read of a context's claim register hands over the best eligible source and marks it as being serviced, so every context stops seeing it. A later write of that source number to the same register kind returns the source to service. Priorities and thresholds are plain stored values. The pending view is read-only, because it only mirrors the request lines.

Reads are registered: `rd_data` carries the value on the clock edge that follows a cycle with `re` high, and it holds that value until the next read. Writes take effect at the clock edge of the cycle in which `we` is high. The default address map is as follows:
- Source priorities start at 0x0000.
- The pending words start at 0x1000.
- The per-context enable windows start at 0x2000, with a stride of 0x80.
- The per-context threshold and claim registers start at 0x4000, with a stride of 0x1000.

Top module: `irq_hub`

## Requirements
- R1: Only word-aligned addresses (addr[1:0] = 0) inside a mapped region are decoded. Any other read returns 0, and any other write changes no state.
- R2: Source 0 is reserved and never delivered. The priority word at byte offset 4*k from the priority base belongs to source k+1.
- R3: A priority write stores only bits [2:0] of the write data, and reading the word back returns that value zero-extended.
- R4: Pending word w is read-only. Its bit b reports the pending state of source 32*w+b. A write to the pending region is dropped.
- R5: While a source's request line is high, its pending bit becomes 1 at the next clock edge. While the line is low, the bit becomes 0.
- R6: Enable word w of context c is at enable base + c*0x80 + 4*w, and its bit b enables source 32*w+b. Only bits of existing sources (1 to NUM_SRC-1) are stored. Word indices at or above the number of source words read 0 and ignore writes.
- R7: The threshold sits at offset 0 of a context window. A write is accepted only when the full 32-bit value is at most 7. Otherwise the old threshold stays.
- R8: irq[c] is 1 exactly when some source is pending, enabled for c, not claimed, and has a priority strictly greater than c's threshold.
- R9: Reading offset 4 of a context window returns the eligible source with the highest priority, and the lowest ID wins a tie. That source's pending bit is cleared and its claimed bit is set. The read returns 0 when nothing is eligible.
- R10: Writing an ID to offset 4 of a context window clears that source's claimed bit if the ID is below NUM_SRC. Larger values are ignored.
- R11: After reset, all priorities, pending, claimed and enable bits and all thresholds are 0, and every irq output is 0.
- R12: When a claim read and a request line act on the same source in the same cycle, the claim's pending clear wins. A line that is still high sets pending again one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| re | input | 1 | Read strobe; a claim read has side effects |
| rd_data | output | 32 | Registered read data |
| src_req | input | NUM_SRC-1 (indices NUM_SRC-1:1) | Level request line of each source 1..NUM_SRC-1 |
| irq | output | NUM_CTX | Interrupt line of each context |

## Verification
The hardest situation to reach is a claim colliding with a request line in the same clock. The claim has to clear a pending bit that the line is still driving high. The outcome is only visible if the pending word is read in the very next cycle. The stimulus therefore issues the claim read and the pending read back to back, so the second read samples the state left by the claim edge. A second pass drops the request line in the same cycle as the claim, to show that pending stays clear. The reuse of a claimed source is driven with a still-high line: the source must stay hidden until the completion write, and it must reappear right after that write.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_PRIO,
      RG_PEND,
      RG_EN,
      RG_THR,
      RG_CLAIM
   } hub_region_e;

   function automatic int unsigned f_words(input int unsigned n);
      return (n + 31) / 32;
   endfunction

   function automatic int unsigned f_idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
   import irq_hub_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned NUM_SRC    = 40,
   parameter int unsigned NUM_CTX    = 2,
   parameter int unsigned PRIO_BASE  = 32'h0000,
   parameter int unsigned PEND_BASE  = 32'h1000,
   parameter int unsigned EN_BASE    = 32'h2000,
   parameter int unsigned EN_STRIDE  = 128,
   parameter int unsigned CTX_BASE   = 32'h4000,
   parameter int unsigned CTX_STRIDE = 4096,
   localparam int unsigned SRC_WORDS = f_words(NUM_SRC),
   localparam int unsigned ID_W      = f_idx_w(NUM_SRC),
   localparam int unsigned WIDX_W    = f_idx_w(SRC_WORDS),
   localparam int unsigned CTX_W     = f_idx_w(NUM_CTX)
) (
   input  logic [ADDR_W-1:0] addr,
   output hub_region_e       region,
   output logic [ID_W-1:0]   src_id,
   output logic [WIDX_W-1:0] word,
   output logic [CTX_W-1:0]  ctx
);

   logic [31:0] a;
   assign a = 32'(addr);

   always_comb begin
      logic [31:0] off;
      region = RG_NONE;
      src_id = '0;
      word   = '0;
      ctx    = '0;
      off    = '0;
      if (a[1:0] == 2'b00) begin
         if (a >= PRIO_BASE && a < PRIO_BASE + (NUM_SRC - 1) * 4) begin
            region = RG_PRIO;
            src_id = ID_W'(((a - PRIO_BASE) >> 2) + 1);
         end else if (a >= PEND_BASE && a < PEND_BASE + SRC_WORDS * 4) begin
            region = RG_PEND;
            word   = WIDX_W'((a - PEND_BASE) >> 2);
         end else if (a >= EN_BASE && a < EN_BASE + NUM_CTX * EN_STRIDE) begin
            off = a - EN_BASE;
            if (((off % EN_STRIDE) >> 2) < SRC_WORDS) begin
               region = RG_EN;
               word   = WIDX_W'((off % EN_STRIDE) >> 2);
               ctx    = CTX_W'(off / EN_STRIDE);
            end
         end else if (a >= CTX_BASE && a < CTX_BASE + NUM_CTX * CTX_STRIDE) begin
            off = a - CTX_BASE;
            ctx = CTX_W'(off / CTX_STRIDE);
            if ((off % CTX_STRIDE) == 0)      region = RG_THR;
            else if ((off % CTX_STRIDE) == 4) region = RG_CLAIM;
         end
      end
   end

endmodule

// File: rtl/irq_hub_src.sv
module irq_hub_src #(
   parameter int unsigned NUM_SRC = 40,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned VEC_W   = 64,
   parameter int unsigned ID_W    = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:1]        src_req,
   input  logic                      prio_we,
   input  logic [ID_W-1:0]           prio_id,
   input  logic [PRIO_W-1:0]         prio_wd,
   input  logic [NUM_SRC-1:1]        claim_set,
   input  logic                      cmpl_we,
   input  logic [ID_W-1:0]           cmpl_id,
   output logic [VEC_W-1:0]          pend_v,
   output logic [VEC_W-1:0]          clm_v,
   output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);

   assign prio_flat[PRIO_W-1:0] = '0;

   for (genvar gi = 0; gi < VEC_W; gi++) begin : g_src
      if (gi == 0 || gi >= NUM_SRC) begin : g_void
         assign pend_v[gi] = 1'b0;
         assign clm_v[gi]  = 1'b0;
      end else begin : g_live
         logic             pend_q;
         logic             clm_q;
         logic [PRIO_W-1:0] prio_q;
         logic             cmpl_hit;

         assign cmpl_hit = cmpl_we && (cmpl_id == ID_W'(gi));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
               clm_q  <= 1'b0;
               prio_q <= '0;
            end else begin
               pend_q <= claim_set[gi] ? 1'b0 : src_req[gi];
               if (claim_set[gi])  clm_q <= 1'b1;
               else if (cmpl_hit)  clm_q <= 1'b0;
               if (prio_we && prio_id == ID_W'(gi)) prio_q <= prio_wd;
            end
         end

         assign pend_v[gi] = pend_q;
         assign clm_v[gi]  = clm_q;
         assign prio_flat[gi*PRIO_W +: PRIO_W] = prio_q;

         AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            claim_set[gi] |=> (clm_v[gi] && !pend_v[gi])); // R9
         AST_CMPL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (cmpl_hit && !claim_set[gi]) |=> !clm_v[gi]); // R10
         AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            !claim_set[gi] |=> (pend_v[gi] == $past(src_req[gi]))); // R5
      end
   end

endmodule

// File: rtl/irq_hub_ctx.sv
module irq_hub_ctx #(
   parameter int unsigned NUM_SRC   = 40,
   parameter int unsigned PRIO_W    = 3,
   parameter int unsigned VEC_W     = 64,
   parameter int unsigned WIDX_W    = 1,
   parameter int unsigned ID_W      = 6,
   parameter bit          REG_IRQ   = 1'b0,
   localparam int unsigned MAX_PRIO = (1 << PRIO_W) - 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [VEC_W-1:0]          pend_v,
   input  logic [VEC_W-1:0]          clm_v,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   input  logic                      en_we,
   input  logic [WIDX_W-1:0]         en_word,
   input  logic                      thr_we,
   input  logic [31:0]               wdata,
   output logic [VEC_W-1:0]          en_o,
   output logic [PRIO_W-1:0]         thr_o,
   output logic [ID_W-1:0]           win_id,
   output logic                      irq_o
);

   logic [VEC_W-1:0]  en_q;
   logic [VEC_W-1:0]  en_mask;
   logic [PRIO_W-1:0] thr_q;
   logic              hit;

   always_comb begin
      en_mask = '0;
      for (int s = 1; s < NUM_SRC; s++) en_mask[s] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         thr_q <= '0;
      end else begin
         if (en_we) en_q[en_word*32 +: 32] <= wdata & en_mask[en_word*32 +: 32];
         if (thr_we && wdata <= 32'(MAX_PRIO)) thr_q <= wdata[PRIO_W-1:0];
      end
   end

   always_comb begin
      logic [PRIO_W-1:0] best_p;
      win_id = '0;
      best_p = thr_q;
      for (int s = 1; s < NUM_SRC; s++) begin
         if (pend_v[s] && !clm_v[s] && en_q[s] &&
             prio_flat[s*PRIO_W +: PRIO_W] > best_p) begin
            win_id = ID_W'(s);
            best_p = prio_flat[s*PRIO_W +: PRIO_W];
         end
      end
   end

   assign hit   = (win_id != '0);
   assign en_o  = en_q;
   assign thr_o = thr_q;

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = hit;

      AST_IRQ_JUSTIFIED: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> (pend_v[win_id] && !clm_v[win_id] && en_o[win_id] &&
                    prio_flat[win_id*PRIO_W +: PRIO_W] > thr_o)); // R8
      AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         (en_o == '0) |-> !irq_o); // R8
   end

   AST_THR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_we && wdata > 32'(MAX_PRIO)) |=> $stable(thr_o)); // R7

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned NUM_SRC    = 40,
   parameter int unsigned NUM_CTX    = 2,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned PRIO_BASE  = 32'h0000,
   parameter int unsigned PEND_BASE  = 32'h1000,
   parameter int unsigned EN_BASE    = 32'h2000,
   parameter int unsigned EN_STRIDE  = 128,
   parameter int unsigned CTX_BASE   = 32'h4000,
   parameter int unsigned CTX_STRIDE = 4096,
   parameter bit          REG_IRQ    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               we,
   input  logic [31:0]        wdata,
   input  logic               re,
   output logic [31:0]        rd_data,
   input  logic [NUM_SRC-1:1] src_req,
   output logic [NUM_CTX-1:0] irq
);

   localparam int unsigned SRC_WORDS = f_words(NUM_SRC);
   localparam int unsigned VEC_W     = SRC_WORDS * 32;
   localparam int unsigned ID_W      = f_idx_w(NUM_SRC);
   localparam int unsigned WIDX_W    = f_idx_w(SRC_WORDS);
   localparam int unsigned CTX_W     = f_idx_w(NUM_CTX);

   if (NUM_SRC < 2 || NUM_SRC > 1024) begin : g_bad_src
      $error("NUM_SRC must lie in 2..1024");
   end
   if (NUM_CTX < 1 || NUM_CTX > 64) begin : g_bad_ctx
      $error("NUM_CTX must lie in 1..64");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must lie in 1..8");
   end
   if ((EN_STRIDE & (EN_STRIDE - 1)) != 0 || EN_STRIDE < SRC_WORDS * 4) begin : g_bad_en
      $error("EN_STRIDE must be a power of two covering all source words");
   end
   if ((CTX_STRIDE & (CTX_STRIDE - 1)) != 0 || CTX_STRIDE < 8) begin : g_bad_cs
      $error("CTX_STRIDE must be a power of two of at least 8");
   end

   hub_region_e       region;
   logic [ID_W-1:0]   d_src;
   logic [WIDX_W-1:0] d_word;
   logic [CTX_W-1:0]  d_ctx;

   irq_hub_decode #(
      .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
      .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE),
      .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
   ) u_dec (
      .addr(addr), .region(region), .src_id(d_src), .word(d_word), .ctx(d_ctx)
   );

   logic [VEC_W-1:0]          pend_v;
   logic [VEC_W-1:0]          clm_v;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [NUM_SRC-1:1]        claim_set;
   logic                      cmpl_we;
   logic [VEC_W-1:0]          en_all  [NUM_CTX];
   logic [PRIO_W-1:0]         thr_all [NUM_CTX];
   logic [ID_W-1:0]           win_all [NUM_CTX];
   logic [NUM_CTX-1:0]        claim_rd;

   assign cmpl_we = we && (region == RG_CLAIM) && (wdata < 32'(NUM_SRC));

   irq_hub_src #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .ID_W(ID_W)
   ) u_src (
      .clk(clk), .rst_n(rst_n), .src_req(src_req),
      .prio_we(we && region == RG_PRIO), .prio_id(d_src),
      .prio_wd(wdata[PRIO_W-1:0]), .claim_set(claim_set),
      .cmpl_we(cmpl_we), .cmpl_id(wdata[ID_W-1:0]),
      .pend_v(pend_v), .clm_v(clm_v), .prio_flat(prio_flat)
   );

   for (genvar gc = 0; gc < NUM_CTX; gc++) begin : g_ctx
      logic sel;
      assign sel          = (d_ctx == CTX_W'(gc));
      assign claim_rd[gc] = re && region == RG_CLAIM && sel;

      irq_hub_ctx #(
         .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
         .WIDX_W(WIDX_W), .ID_W(ID_W), .REG_IRQ(REG_IRQ)
      ) u_ctx (
         .clk(clk), .rst_n(rst_n), .pend_v(pend_v), .clm_v(clm_v),
         .prio_flat(prio_flat),
         .en_we(we && region == RG_EN && sel), .en_word(d_word),
         .thr_we(we && region == RG_THR && sel), .wdata(wdata),
         .en_o(en_all[gc]), .thr_o(thr_all[gc]), .win_id(win_all[gc]),
         .irq_o(irq[gc])
      );
   end

   always_comb begin
      claim_set = '0;
      for (int c = 0; c < NUM_CTX; c++) begin
         if (claim_rd[c] && win_all[c] != '0) claim_set[win_all[c]] = 1'b1;
      end
   end

   logic [31:0] rd_val;

   always_comb begin
      case (region)
         RG_PRIO:  rd_val = 32'(prio_flat[d_src*PRIO_W +: PRIO_W]);
         RG_PEND:  rd_val = pend_v[d_word*32 +: 32];
         RG_EN:    rd_val = en_all[d_ctx][d_word*32 +: 32];
         RG_THR:   rd_val = 32'(thr_all[d_ctx]);
         RG_CLAIM: rd_val = 32'(win_all[d_ctx]);
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rd_data <= '0;
      else if (re) rd_data <= rd_val;
   end

   AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(claim_set)); // R9
   AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (re && addr[1:0] != 2'b00) |=> (rd_data == 32'd0)); // R1
   AST_CLAIM_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (re && region == RG_CLAIM) |=> (rd_data < 32'(NUM_SRC))); // R9

endmodule

// File: tb/tb_irq_hub.sv
`timescale 1ns/1ps
module tb_irq_hub;

   localparam int NSRC = 40;
   localparam int NCTX = 2;
   localparam logic [15:0] PEND = 16'h1000;
   localparam logic [15:0] EN0  = 16'h2000;
   localparam logic [15:0] EN1  = 16'h2080;
   localparam logic [15:0] THR0 = 16'h4000;
   localparam logic [15:0] CLM0 = 16'h4004;
   localparam logic [15:0] THR1 = 16'h5000;
   localparam logic [15:0] CLM1 = 16'h5004;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [15:0]     addr = '0;
   logic            we = 1'b0;
   logic [31:0]     wdata = '0;
   logic            re = 1'b0;
   logic [31:0]     rd_data;
   logic [NSRC-1:1] src_req = '0;
   logic [NCTX-1:0] irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_hub dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
      .re(re), .rd_data(rd_data), .src_req(src_req), .irq(irq)
   );

   function automatic logic [15:0] prio_a(input int id);
      return 16'((id - 1) * 4);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      addr = a; re = 1'b1;
      @(negedge clk);
      d = rd_data;
      re = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic t_reset();
      chk("R11 irq after reset", 32'(irq), 32'd0);
      rd_chk("R11 pending after reset", PEND, 32'd0);
      rd_chk("R11 threshold after reset", THR0, 32'd0);
      rd_chk("R11 priority after reset", prio_a(1), 32'd0);
      rd_chk("R11 enable after reset", EN0, 32'd0);
      rd_chk("R9 empty claim", CLM0, 32'd0);
   endtask

   task automatic t_prio();
      wr(prio_a(3), 32'hFF);
      rd_chk("R3 priority keeps low bits", prio_a(3), 32'd7);
      wr(prio_a(3), 32'h0);
   endtask

   task automatic t_pending();
      src_req[5] = 1'b1;
      @(negedge clk);
      rd_chk("R5 pending follows high level", PEND, 32'h20);
      wr(PEND, 32'h0);
      rd_chk("R4 pending write dropped", PEND, 32'h20);
      src_req[5] = 1'b0;
      src_req[33] = 1'b1;
      @(negedge clk);
      rd_chk("R5 pending follows low level", PEND, 32'h0);
      rd_chk("R4 second pending word", PEND + 16'd4, 32'h2);
      src_req[33] = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_threshold();
      src_req[5] = 1'b1;
      wr(prio_a(5), 32'd2);
      wr(EN0, 32'h20);
      wr(THR0, 32'd2);
      chk("R8 equal priority not delivered", 32'(irq[0]), 32'd0);
      wr(THR0, 32'd1);
      chk("R8 above threshold delivered", 32'(irq[0]), 32'd1);
      chk("R8 other context not enabled", 32'(irq[1]), 32'd0);
      wr(THR0, 32'd8);
      rd_chk("R7 oversize threshold rejected", THR0, 32'd1);
      wr(THR0, 32'd7);
      rd_chk("R7 maximum threshold accepted", THR0, 32'd7);
      chk("R8 masked by threshold", 32'(irq[0]), 32'd0);
      wr(THR0, 32'd0);
   endtask

   task automatic t_claim();
      wr(prio_a(9), 32'd5);
      wr(EN0, 32'h220);
      src_req[9] = 1'b1;
      @(negedge clk);
      rd_chk("R9 R2 highest priority claimed", CLM0, 32'd9);
      chk("R8 remaining source still raises", 32'(irq[0]), 32'd1);
      rd_chk("R9 next claim", CLM0, 32'd5);
      chk("R8 claimed sources masked", 32'(irq[0]), 32'd0);
      rd_chk("R9 nothing left to claim", CLM0, 32'd0);
      rd_chk("R12 high level re-sets pending", PEND, 32'h220);
      wr(CLM0, 32'd69);
      chk("R10 out-of-range completion ignored", 32'(irq[0]), 32'd0);
      wr(CLM0, 32'd9);
      chk("R10 completion re-enables source", 32'(irq[0]), 32'd1);
      rd_chk("R10 completed source claimable", CLM0, 32'd9);
      src_req[5] = 1'b0;
      src_req[9] = 1'b0;
      wr(CLM0, 32'd9);
      wr(CLM0, 32'd5);
      chk("R8 idle after completion", 32'(irq), 32'd0);
   endtask

   task automatic t_tie();
      wr(prio_a(7), 32'd3);
      wr(prio_a(12), 32'd3);
      wr(EN1, 32'h1080);
      src_req[7] = 1'b1;
      src_req[12] = 1'b1;
      @(negedge clk);
      chk("R8 context 1 raised", 32'(irq), 32'h2);
      rd_chk("R9 tie goes to lowest ID", CLM1, 32'd7);
      rd_chk("R9 tie second claim", CLM1, 32'd12);
      src_req[7] = 1'b0;
      src_req[12] = 1'b0;
      wr(CLM1, 32'd7);
      wr(CLM1, 32'd12);
      chk("R10 context 1 quiet", 32'(irq), 32'd0);
   endtask

   task automatic t_window();
      wr(EN0 + 16'd4, 32'hFFFF_FFFF);
      rd_chk("R6 only existing sources stored", EN0 + 16'd4, 32'h0000_00FF);
      wr(EN0 + 16'd8, 32'hFFFF_FFFF);
      rd_chk("R6 word past sources reads zero", EN0 + 16'd8, 32'd0);
      rd_chk("R6 neighbour word untouched", EN0 + 16'd4, 32'h0000_00FF);
      wr(EN0 + 16'd4, 32'd0);
   endtask

   task automatic t_align();
      wr(prio_a(1), 32'd4);
      rd_chk("R2 word zero is source one", prio_a(1), 32'd4);
      rd_chk("R1 misaligned read zero", prio_a(1) + 16'd2, 32'd0);
      wr(prio_a(1) + 16'd2, 32'd1);
      rd_chk("R1 misaligned write ignored", prio_a(1), 32'd4);
      rd_chk("R1 unmapped read zero", 16'h3000, 32'd0);
      wr(prio_a(1), 32'd0);
   endtask

   task automatic t_race();
      logic [31:0] v;
      wr(prio_a(20), 32'd6);
      wr(EN0, 32'h0010_0000);
      src_req[20] = 1'b1;
      @(negedge clk);
      rd_chk("R9 claim source 20", CLM0, 32'd20);
      rd(PEND, v);
      chk("R12 claim clear wins", v & 32'h0010_0000, 32'd0);
      rd(PEND, v);
      chk("R12 level re-sets next cycle", v & 32'h0010_0000, 32'h0010_0000);
      wr(CLM0, 32'd20);
      src_req[20] = 1'b0;
      rd_chk("R12 claim with falling level", CLM0, 32'd20);
      rd(PEND, v);
      chk("R12 pending stays clear", v & 32'h0010_0000, 32'd0);
      wr(CLM0, 32'd20);
      chk("R8 idle at end", 32'(irq), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prio();
      t_pending();
      t_threshold();
      t_claim();
      t_tie();
      t_window();
      t_align();
      t_race();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule